// File: doc/BRIEF.md
# Opcode-Fetch Byte Substitution Decoder

This block watches a Z80-style processor bus and replaces exactly one byte of fixed program memory. It does so only when the processor fetches that byte as an opcode. When the active-low fetch, memory-request and read strobes are all low and the address equals the configured location, the block pulls an active-low memory-disable strobe. That strobe silences every ROM and RAM device on the data bus. In the same cycle the block drives its own replacement opcode. The default patch turns a branch-if-non-zero byte (0x20) at 0x006D into a branch-if-zero (0x28). With that change, the non-maskable interrupt handler entered at 0x0066 jumps to a user routine instead of clearing the machine.

Ordinary data reads of the same address are left alone, so they still return the real ROM byte. Refresh cycles are left alone too. A static enable input can switch the patch off. The same decoder also makes a pair of fully decoded active-low select pulses for 8-bit I/O port 0x6D: one for port reads and one for port writes.

All outputs are combinational functions of the bus pins. A result appears in the same bus cycle as the strobes that cause it. The data byte is presented as a value plus an output-enable for the pad's tri-state driver. No streaming interface exists here, so every pin is a plain level.

Top module: `fetch_patch_top`

## Requirements
- R1: With `patch_en`=1 and `rst_n`=1, `m1_n`=0, `mreq_n`=0, `rd_n`=0 and `addr`=0x006D together drive `bus_dis_n` low in the same cycle.
- R2: Whenever `bus_dis_n` is low, `dbus_oe` is 1 and `dbus_out` is 0x28. Whenever `dbus_oe` is 0, `dbus_out` reads 0x00.
- R3: A refresh cycle (`m1_n`=1, `mreq_n`=0, `rd_n`=1) never lowers `bus_dis_n` and never raises `dbus_oe`, at any address.
- R4: A data read of 0x006D (`m1_n`=1, `mreq_n`=0, `rd_n`=0) leaves `bus_dis_n` high and `dbus_oe` 0, so the real memory answers.
- R5: An opcode fetch from any address other than 0x006D leaves `bus_dis_n` high and `dbus_oe` 0.
- R6: With `patch_en`=0, `bus_dis_n` stays high and `dbus_oe` stays 0 for every bus pattern.
- R7: `dbus_oe` is 0 in any cycle where `rd_n` or `mreq_n` is high. The driver releases in the same cycle that either strobe deasserts.
- R8: `in_sel_n` is low exactly when `iorq_n`=0, `m1_n`=1, `rd_n`=0 and `addr[7:0]`=0x6D. The upper address byte is ignored.
- R9: `out_sel_n` is low exactly when `iorq_n`=0, `m1_n`=1, `wr_n`=0 and `addr[7:0]`=0x6D.
- R10: An interrupt-acknowledge cycle (`m1_n`=0, `iorq_n`=0) asserts neither I/O select.
- R11: While `rst_n`=0, every output is inactive: `bus_dis_n`=1, `dbus_oe`=0, `dbus_out`=0x00, `in_sel_n`=1, `out_sel_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, used for the sampled checks |
| rst_n | input | 1 | Active-low reset, forces all outputs inactive |
| patch_en | input | 1 | 1 enables the opcode substitution |
| addr | input | 16 | Processor address bus |
| m1_n | input | 1 | Active-low opcode-fetch cycle marker |
| mreq_n | input | 1 | Active-low memory request |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_dis_n | output | 1 | Active-low disable for all ROM and RAM |
| dbus_out | output | 8 | Replacement byte for the data bus pad |
| dbus_oe | output | 1 | Output-enable for the data bus pad driver |
| in_sel_n | output | 1 | Active-low read select for I/O port 0x6D |
| out_sel_n | output | 1 | Active-low write select for I/O port 0x6D |

## Verification
Every result of this block is due in the same cycle as the bus strobes that cause it, so zero register stages lie between stimulus and response. The bench applies each bus pattern on the falling clock edge. It compares all five outputs against its behavioural model one nanosecond later, well before the next rising edge at which the embedded properties sample. Directed patterns cover fetch, refresh, data read, wrong address, disabled patch, strobe release, I/O read and write, interrupt acknowledge and reset. A stretch of pseudo-random patterns biased toward the patched address follows.

// File: rtl/fetch_patch_pkg.sv
package fetch_patch_pkg;
  localparam int unsigned BUS_AW = 16;
  localparam int unsigned BUS_DW = 8;
  localparam int unsigned PORT_AW = 8;
  localparam logic [BUS_AW-1:0] DEF_PATCH_ADDR = 16'h006D;
  localparam logic [BUS_DW-1:0] DEF_PATCH_BYTE = 8'h28;
  localparam logic [PORT_AW-1:0] DEF_IO_PORT = 8'h6D;
endpackage

// File: rtl/fetch_addr_match.sv
module fetch_addr_match #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] MATCH_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic          m1_n,
  input  logic          mreq_n,
  input  logic          rd_n,
  output logic          hit
);
  logic addr_eq;
  logic fetch_rd;

  assign addr_eq  = (addr == MATCH_ADDR);
  assign fetch_rd = ~m1_n & ~mreq_n & ~rd_n;
  assign hit      = rst_n & en & fetch_rd & addr_eq;

  // refresh cycles carry m1_n high and must never match
  p_refresh_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_n && !mreq_n && rd_n) |-> !hit);
  p_data_read_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m1_n |-> !hit);
endmodule

// File: rtl/patch_drive.sv
module patch_drive #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] SUB_BYTE = '0
) (
  input  logic          hit,
  output logic          dis_n,
  output logic [DW-1:0] dout,
  output logic          oe
);
  assign dis_n = ~hit;
  assign oe    = hit;
  assign dout  = hit ? SUB_BYTE : '0;
endmodule

// File: rtl/io_port_select.sv
module io_port_select #(
  parameter int unsigned PW = 8,
  parameter logic [PW-1:0] PORT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] port_addr,
  input  logic          m1_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          in_sel_n,
  output logic          out_sel_n
);
  logic io_cycle;

  assign io_cycle  = rst_n & ~iorq_n & m1_n & (port_addr == PORT);
  assign in_sel_n  = ~(io_cycle & ~rd_n);
  assign out_sel_n = ~(io_cycle & ~wr_n);

  // interrupt acknowledge must not look like a port access
  p_ack_no_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && !iorq_n) |-> (in_sel_n && out_sel_n));
  p_single_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n) |-> $onehot0({~in_sel_n, ~out_sel_n}));
  p_out_needs_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_sel_n |-> (!wr_n && !iorq_n));
endmodule

// File: rtl/fetch_patch_top.sv
module fetch_patch_top
  import fetch_patch_pkg::*;
#(
  parameter int unsigned AW = BUS_AW,
  parameter int unsigned DW = BUS_DW,
  parameter int unsigned PW = PORT_AW,
  parameter logic [AW-1:0] PATCH_ADDR = DEF_PATCH_ADDR,
  parameter logic [DW-1:0] PATCH_BYTE = DEF_PATCH_BYTE,
  parameter logic [PW-1:0] IO_PORT = DEF_IO_PORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          patch_en,
  input  logic [AW-1:0] addr,
  input  logic          m1_n,
  input  logic          mreq_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          bus_dis_n,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_oe,
  output logic          in_sel_n,
  output logic          out_sel_n
);
  logic fetch_hit;

  fetch_addr_match #(.AW(AW), .MATCH_ADDR(PATCH_ADDR)) u_match (
    .clk(clk), .rst_n(rst_n), .en(patch_en), .addr(addr),
    .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n), .hit(fetch_hit)
  );

  patch_drive #(.DW(DW), .SUB_BYTE(PATCH_BYTE)) u_drive (
    .hit(fetch_hit), .dis_n(bus_dis_n), .dout(dbus_out), .oe(dbus_oe)
  );

  io_port_select #(.PW(PW), .PORT(IO_PORT)) u_io (
    .clk(clk), .rst_n(rst_n), .port_addr(addr[PW-1:0]),
    .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .in_sel_n(in_sel_n), .out_sel_n(out_sel_n)
  );

  p_fetch_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (patch_en && !m1_n && !mreq_n && !rd_n && addr == PATCH_ADDR) |-> !bus_dis_n);
  p_byte_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dis_n |-> (dbus_oe && dbus_out == PATCH_BYTE));
  p_other_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != PATCH_ADDR) |-> (bus_dis_n && !dbus_oe));
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !patch_en |-> (bus_dis_n && !dbus_oe));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || mreq_n) |-> !dbus_oe);
  p_release_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !dbus_oe);
endmodule

// File: tb/fetch_patch_top_tb.sv
module fetch_patch_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic patch_en = 1'b0;
  logic [15:0] addr = '0;
  logic m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic bus_dis_n, dbus_oe, in_sel_n, out_sel_n;
  logic [7:0] dbus_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_patch_top u_dut (
    .clk(clk), .rst_n(rst_n), .patch_en(patch_en), .addr(addr),
    .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_dis_n(bus_dis_n), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
    .in_sel_n(in_sel_n), .out_sel_n(out_sel_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, one bus cycle, outputs due in the same cycle
  task automatic cyc(input string tag, input bit rst, input bit en, input logic [15:0] a,
                     input bit m1, input bit mreq, input bit iorq, input bit rd, input bit wr);
    bit fetch, io;
    @(negedge clk);
    rst_n = rst; patch_en = en; addr = a;
    m1_n = m1; mreq_n = mreq; iorq_n = iorq; rd_n = rd; wr_n = wr;
    fetch = rst && en && !m1 && !mreq && !rd && (a == 16'h006D);
    io    = rst && !iorq && m1 && (a[7:0] == 8'h6D);
    #1;
    chk(tag, "bus_dis_n", int'(bus_dis_n), fetch ? 0 : 1);
    chk(tag, "dbus_oe",   int'(dbus_oe),   fetch ? 1 : 0);
    chk(tag, "dbus_out",  int'(dbus_out),  fetch ? 'h28 : 0);
    chk(tag, "in_sel_n",  int'(in_sel_n),  (io && !rd) ? 0 : 1);
    chk(tag, "out_sel_n", int'(out_sel_n), (io && !wr) ? 0 : 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset holds everything inactive, even on a matching fetch
    cyc("R11", 0, 1, 16'h006D, 0, 0, 1, 0, 1);
    cyc("R11", 0, 1, 16'h006D, 1, 1, 0, 0, 0);
    cyc("R1", 1, 1, 16'h0000, 1, 1, 1, 1, 1);
    // R1 R2 patched opcode fetch
    cyc("R1", 1, 1, 16'h006D, 0, 0, 1, 0, 1);
    cyc("R2", 1, 1, 16'h006D, 0, 0, 1, 0, 1);
    // R7 release as rd_n rises, then mreq_n rises
    cyc("R7", 1, 1, 16'h006D, 0, 0, 1, 1, 1);
    cyc("R2", 1, 1, 16'h006D, 0, 0, 1, 0, 1);
    cyc("R7", 1, 1, 16'h006D, 0, 1, 1, 0, 1);
    // R3 refresh cycles at the patched and other addresses
    cyc("R3", 1, 1, 16'h006D, 1, 0, 1, 1, 1);
    cyc("R3", 1, 1, 16'h3F6D, 1, 0, 1, 1, 1);
    // R4 data read of the patched location
    cyc("R4", 1, 1, 16'h006D, 1, 0, 1, 0, 1);
    // R5 fetches from neighbours and an alias in the high byte
    cyc("R5", 1, 1, 16'h006C, 0, 0, 1, 0, 1);
    cyc("R5", 1, 1, 16'h0066, 0, 0, 1, 0, 1);
    cyc("R5", 1, 1, 16'h016D, 0, 0, 1, 0, 1);
    // R6 patch disabled
    cyc("R6", 1, 0, 16'h006D, 0, 0, 1, 0, 1);
    // R8 R9 port accesses, upper byte ignored
    cyc("R8", 1, 1, 16'h006D, 1, 1, 0, 0, 1);
    cyc("R8", 1, 1, 16'hA56D, 1, 1, 0, 0, 1);
    cyc("R8", 1, 1, 16'h006E, 1, 1, 0, 0, 1);
    cyc("R9", 1, 1, 16'h126D, 1, 1, 0, 1, 0);
    cyc("R9", 1, 1, 16'h006D, 1, 1, 1, 1, 0);
    // R10 interrupt acknowledge
    cyc("R10", 1, 1, 16'h006D, 0, 1, 0, 1, 1);
    cyc("R10", 1, 1, 16'h006D, 0, 1, 0, 0, 0);
    // mixed patterns biased toward the patched address
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [4:0] s;
      a = ($urandom % 3 == 0) ? 16'($urandom) : (($urandom % 2 == 0) ? 16'h006D : 16'h446D);
      s = 5'($urandom);
      if (!s[4] && !s[3]) s[3] = 1'b1; // keep mreq_n and iorq_n from both being low
      cyc("R1", 1, ($urandom % 5) != 0, a, s[0], s[3], s[4], s[1], s[2] | ~s[1]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule